// File: doc/BRIEF.md
# Dual-Buffer Page Operation Sequencer

This block runs the write and maintenance commands of a paged serial flash that holds two page-sized SRAM buffers beside its main array. It receives the serial stream already packed into bytes and framed by an active-low chip select. While chip select is low it decodes an opcode and a three-byte address. For a program-through-buffer command it also writes each further byte into the chosen buffer.

When chip select rises, the block commits the decoded command as a self-timed internal operation. The operation is one of the following:
- erase-and-program of a page from a buffer
- transfer of a page into a buffer
- byte-by-byte comparison of a page against a buffer
- rewrite, which copies a page into a buffer and then programs it back

A ready flag and a status byte report progress and the last comparison result. The array is an inferred RAM sized by a page-count parameter. Operation lengths are parameters counted in clock cycles.

Top module: `dbuf_page_seq`

## Requirements
- R1: After reset `ready` is 1, `st_byte` is 0x80 and `st_vld` is 0; every array and buffer byte powers up as 0xFF.
- R2: Opcode 0x82 selects buffer 1 and 0x85 selects buffer 2 for program-through-buffer. Three address bytes follow the opcode: 4 reserved bits, then an 11-bit page number (taken modulo PAGES), then a 9-bit start byte (a value of 264 or more is reduced by 264). Each further byte is stored in the buffer at consecutive addresses. On chip-select rise the page is erased to 0xFF and then loaded with the whole buffer.
- R3: When the buffer write address passes byte 263, the next data byte goes to byte 0 of the same buffer.
- R4: `ready` falls only at the clock edge that first samples `cs_n` high after a launched command. It stays low for exactly T_EP cycles for program and rewrite, and for exactly T_XFR cycles for transfer and compare.
- R5: Opcode 0x53 (buffer 1) or 0x55 (buffer 2), followed by three address bytes, copies the addressed page into the buffer once chip select rises.
- R6: Opcode 0x60 (buffer 1) or 0x61 (buffer 2) compares all 264 bytes of the page with the buffer. Status bit 6 becomes 0 on a full match and 1 on any difference, and it changes only at the edge where `ready` returns high.
- R7: Opcode 0x58 (buffer 1) or 0x59 (buffer 2) copies the page into the buffer, then erases the same page and programs it from that buffer.
- R8: Opcode 0x57 or 0xD7 raises `st_vld` one cycle after the opcode byte and holds it until `cs_n` is high. `st_byte` bit 7 is 1 when ready and 0 when busy, bit 6 is the compare result, and bits 5..0 are 0.
- R9: While busy, any opcode other than a status read is ignored: no buffer or array byte changes and no further operation starts.
- R10: If chip select rises before the opcode and all three address bytes have arrived, or if the opcode is unknown, no operation is launched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select framing one command |
| rx_vld | input | 1 | A received byte is present on `rx_byte` this cycle |
| rx_byte | input | 8 | Received command, address or data byte |
| ready | output | 1 | 1 when idle, 0 while an internal operation runs |
| st_byte | output | 8 | Status byte: bit 7 ready, bit 6 compare mismatch |
| st_vld | output | 1 | A status read command is active |

## Verification
Chip select is released at a falling clock edge. The next rising edge launches the operation, and `ready` is then low on exactly T_EP or T_XFR consecutive falling-edge samples. The bench counts those samples, and in one scenario it counts absolute cycles across stimuli that arrive mid-operation. The compare bit is read at the first falling edge where `ready` is seen high again, because it is written at that same rising edge. `st_vld` is sampled at the falling edge right after the opcode byte was clocked in. Array and buffer contents are observed only through compare results, which are predicted from a byte-level model of both memories kept in the bench.

// File: rtl/dbuf_page_seq.sv
module dbuf_page_seq #(
  parameter int PAGE_BYTES = 264,
  parameter int PAGES      = 8,
  parameter int T_XFR      = 300,
  parameter int T_EP       = 820
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rx_vld,
  input  logic [7:0] rx_byte,
  output logic       ready,
  output logic [7:0] st_byte,
  output logic       st_vld
);

  localparam int BAW  = $clog2(PAGE_BYTES);
  localparam int PAW  = $clog2(PAGES);
  localparam int MEMW = $clog2(PAGES * PAGE_BYTES);
  localparam int BUFW = $clog2(2 * PAGE_BYTES);
  localparam int TW   = $clog2(T_EP + 1);

  typedef enum logic [2:0] {K_NONE, K_PRG, K_XFR, K_CMP, K_RWR, K_STS} kind_t;
  typedef enum logic [2:0] {S_IDLE, S_XFR, S_CMP, S_ERS, S_PRG, S_WAIT} st_t;

  logic [7:0] arr  [PAGES*PAGE_BYTES];
  logic [7:0] bufm [2*PAGE_BYTES];

  initial begin
    for (int i = 0; i < PAGES*PAGE_BYTES; i++) arr[i] = 8'hFF;
    for (int i = 0; i < 2*PAGE_BYTES; i++) bufm[i] = 8'hFF;
  end

  function automatic logic [BUFW-1:0] bidx(input logic s, input logic [BAW-1:0] a);
    return s ? BUFW'(PAGE_BYTES) + BUFW'(a) : BUFW'(a);
  endfunction

  // command capture
  logic           cs_q;
  logic [2:0]     bcnt;
  kind_t          kind, dec_kind;
  logic           bsel, dec_sel;
  logic [3:0]     pg_hi;
  logic           sa_hi;
  logic [PAW-1:0] pg_r;
  logic [BAW-1:0] wp, wp_next, sa_fold;
  logic [8:0]     sa_raw;
  logic [10:0]    pg_full;
  logic           data_wr, launch;

  // execution
  st_t             state;
  logic            ex_sel, ex_rwr, cmp_run, acc, mis;
  logic [MEMW-1:0] ex_base;
  logic [BAW-1:0]  ix;
  logic [TW-1:0]   tmr;
  logic            last, busy;

  logic            buf_we, arr_we;
  logic [BUFW-1:0] buf_wa;
  logic [MEMW-1:0] arr_wa;
  logic [7:0]      buf_wd, arr_wd, arr_rd, buf_rd;

  assign busy    = (state != S_IDLE);
  assign ready   = ~busy;
  assign st_byte = {ready, mis, 6'b0};

  always_comb begin
    dec_kind = K_NONE;
    dec_sel  = 1'b0;
    case (rx_byte)
      8'h82: dec_kind = K_PRG;
      8'h85: begin dec_kind = K_PRG; dec_sel = 1'b1; end
      8'h53: dec_kind = K_XFR;
      8'h55: begin dec_kind = K_XFR; dec_sel = 1'b1; end
      8'h60: dec_kind = K_CMP;
      8'h61: begin dec_kind = K_CMP; dec_sel = 1'b1; end
      8'h58: dec_kind = K_RWR;
      8'h59: begin dec_kind = K_RWR; dec_sel = 1'b1; end
      8'h57, 8'hD7: dec_kind = K_STS;
      default: dec_kind = K_NONE;
    endcase
  end

  assign sa_raw  = {sa_hi, rx_byte};
  assign sa_fold = (int'(sa_raw) >= PAGE_BYTES) ? BAW'(int'(sa_raw) - PAGE_BYTES) : BAW'(sa_raw);
  assign pg_full = {pg_hi, rx_byte[7:1]};
  assign wp_next = (wp == BAW'(PAGE_BYTES - 1)) ? '0 : wp + 1'b1;
  assign data_wr = !cs_n && rx_vld && (bcnt == 3'd4) && (kind == K_PRG);
  assign launch  = cs_n && !cs_q && (bcnt == 3'd4) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      bcnt   <= '0;
      kind   <= K_NONE;
      bsel   <= 1'b0;
      pg_hi  <= '0;
      sa_hi  <= 1'b0;
      pg_r   <= '0;
      wp     <= '0;
      st_vld <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (cs_n) begin
        bcnt   <= '0;
        st_vld <= 1'b0;
      end else if (rx_vld) begin
        if (bcnt != 3'd4) bcnt <= bcnt + 3'd1;
        case (bcnt)
          3'd0: begin
            kind   <= (busy && dec_kind != K_STS) ? K_NONE : dec_kind;
            bsel   <= dec_sel;
            st_vld <= (dec_kind == K_STS);
          end
          3'd1: pg_hi <= rx_byte[3:0];
          3'd2: begin
            pg_r  <= PAW'(pg_full % 11'(PAGES));
            sa_hi <= rx_byte[0];
          end
          3'd3: wp <= sa_fold;
          default: if (data_wr) wp <= wp_next;
        endcase
      end
    end
  end

  assign last   = (ix == BAW'(PAGE_BYTES - 1));
  assign arr_rd = arr[ex_base + MEMW'(ix)];
  assign buf_rd = bufm[bidx(ex_sel, ix)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ex_sel  <= 1'b0;
      ex_rwr  <= 1'b0;
      ex_base <= '0;
      cmp_run <= 1'b0;
      acc     <= 1'b0;
      mis     <= 1'b0;
      ix      <= '0;
      tmr     <= '0;
    end else begin
      if (busy && tmr != '0) tmr <= tmr - 1'b1;
      case (state)
        S_IDLE: if (launch && kind != K_NONE && kind != K_STS) begin
          ex_sel  <= bsel;
          ex_base <= MEMW'(pg_r) * MEMW'(PAGE_BYTES);
          ix      <= '0;
          ex_rwr  <= (kind == K_RWR);
          cmp_run <= (kind == K_CMP);
          acc     <= 1'b0;
          case (kind)
            K_PRG:   begin state <= S_ERS; tmr <= TW'(T_EP - 1);  end
            K_RWR:   begin state <= S_XFR; tmr <= TW'(T_EP - 1);  end
            K_XFR:   begin state <= S_XFR; tmr <= TW'(T_XFR - 1); end
            default: begin state <= S_CMP; tmr <= TW'(T_XFR - 1); end
          endcase
        end
        S_XFR: begin
          ix <= last ? '0 : ix + 1'b1;
          if (last) state <= ex_rwr ? S_ERS : S_WAIT;
        end
        S_CMP: begin
          acc <= acc | (arr_rd != buf_rd);
          ix  <= last ? '0 : ix + 1'b1;
          if (last) state <= S_WAIT;
        end
        S_ERS: begin
          ix <= last ? '0 : ix + 1'b1;
          if (last) state <= S_PRG;
        end
        S_PRG: begin
          ix <= last ? '0 : ix + 1'b1;
          if (last) state <= S_WAIT;
        end
        default: if (tmr == '0) begin
          state <= S_IDLE;
          if (cmp_run) mis <= acc;
        end
      endcase
    end
  end

  always_comb begin
    if (state == S_XFR) begin
      buf_we = 1'b1;
      buf_wa = bidx(ex_sel, ix);
      buf_wd = arr_rd;
    end else begin
      buf_we = data_wr;
      buf_wa = bidx(bsel, wp);
      buf_wd = rx_byte;
    end
    arr_we = (state == S_ERS) || (state == S_PRG);
    arr_wa = ex_base + MEMW'(ix);
    arr_wd = (state == S_ERS) ? 8'hFF : buf_rd;
  end

  always_ff @(posedge clk) begin
    if (buf_we) bufm[buf_wa] <= buf_wd;
    if (arr_we) arr[arr_wa] <= arr_wd;
  end

endmodule

// File: rtl/dbuf_page_seq_chk.sv
module dbuf_page_seq_chk #(
  parameter int T_XFR = 300,
  parameter int T_EP  = 820
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rx_vld,
  input logic ready,
  input logic st_mis,
  input logic st_vld
);

  logic        cs_q;
  logic [2:0]  cb;
  logic [15:0] bl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
      cb   <= '0;
      bl   <= '0;
    end else begin
      cs_q <= cs_n;
      if (cs_n) cb <= '0;
      else if (rx_vld && cb != 3'd4) cb <= cb + 3'd1;
      bl <= ready ? '0 : bl + 16'd1;
    end
  end

  AST_ABORT_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !cs_q && cb < 3'd4 && ready) |=> ready); // R10
  AST_LAUNCH_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(cs_n && !cs_q)); // R4
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (bl == 16'(T_XFR) || bl == 16'(T_EP))); // R4
  AST_STS_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld |-> $past(!cs_n)); // R8
  AST_MIS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(st_mis) |-> $rose(ready)); // R6

endmodule

bind dbuf_page_seq dbuf_page_seq_chk #(.T_XFR(T_XFR), .T_EP(T_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_vld(rx_vld),
  .ready(ready), .st_mis(st_byte[6]), .st_vld(st_vld)
);

// File: tb/dbuf_page_seq_bench.sv
`timescale 1ns/1ps
module dbuf_page_seq_bench;
  localparam int PB    = 264;
  localparam int PAGES = 8;
  localparam int TX    = 300;
  localparam int TE    = 820;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       rx_vld = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       ready;
  logic [7:0] st_byte;
  logic       st_vld;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [7:0] m_arr [PAGES*PB];
  logic [7:0] m_buf [2*PB];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbuf_page_seq #(.PAGE_BYTES(PB), .PAGES(PAGES), .T_XFR(TX), .T_EP(TE)) u_dbuf_page_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .ready(ready), .st_byte(st_byte), .st_vld(st_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); rx_vld = 1'b1; rx_byte = b;
    @(negedge clk); rx_vld = 1'b0;
  endtask

  task automatic hdr(input logic [7:0] op, input logic [10:0] pg, input logic [8:0] sa);
    @(negedge clk); cs_n = 1'b0;
    put(op);
    put({4'b0, pg[10:7]});
    put({pg[6:0], sa[8]});
    put(sa[7:0]);
  endtask

  task automatic finish_busy(input int exp_t, input string req);
    int n = 0;
    @(negedge clk); cs_n = 1'b1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (ready) break;
      n++;
    end
    chk(n == exp_t, req, n, exp_t);
  endtask

  task automatic do_xfer(input bit s, input int pg);
    hdr(s ? 8'h55 : 8'h53, 11'(pg), 9'd0);
    finish_busy(TX, "R4 transfer length");
    for (int i = 0; i < PB; i++) m_buf[s*PB+i] = m_arr[pg*PB+i];
  endtask

  task automatic do_prog(input bit s, input int pg, input int sa, input logic [7:0] d [4], input int n, input string req);
    int a = sa;
    hdr(s ? 8'h85 : 8'h82, 11'(pg), 9'(sa));
    for (int i = 0; i < n; i++) begin
      put(d[i]);
      m_buf[s*PB+a] = d[i];
      a = (a == PB-1) ? 0 : a + 1;
    end
    finish_busy(TE, req);
    for (int i = 0; i < PB; i++) m_arr[pg*PB+i] = m_buf[s*PB+i];
  endtask

  task automatic do_cmp(input bit s, input int pg, input string req);
    bit exp_mis = 1'b0;
    for (int i = 0; i < PB; i++) if (m_arr[pg*PB+i] != m_buf[s*PB+i]) exp_mis = 1'b1;
    hdr(s ? 8'h61 : 8'h60, 11'(pg), 9'd0);
    finish_busy(TX, "R4 compare length");
    chk(st_byte[6] == exp_mis, req, int'(st_byte[6]), int'(exp_mis));
    chk(st_byte[7] == 1'b1, "R8 ready bit after compare", int'(st_byte[7]), 1);
  endtask

  task automatic do_rwr(input bit s, input int pg);
    hdr(s ? 8'h59 : 8'h58, 11'(pg), 9'd0);
    finish_busy(TE, "R7 rewrite length");
    for (int i = 0; i < PB; i++) m_buf[s*PB+i] = m_arr[pg*PB+i];
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready", int'(ready), 1);
    chk(st_byte == 8'h80, "R1 status", int'(st_byte), 'h80);
    chk(st_vld == 1'b0, "R1 st_vld", int'(st_vld), 0);
  endtask

  task automatic t_status_idle;
    @(negedge clk); cs_n = 1'b0;
    put(8'hD7);
    chk(st_vld == 1'b1, "R8 st_vld", int'(st_vld), 1);
    chk(st_byte == 8'h80, "R8 idle status", int'(st_byte), 'h80);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk(st_vld == 1'b0, "R8 st_vld drop", int'(st_vld), 0);
  endtask

  task automatic t_prog_wrap;
    do_prog(1'b1, 2, 0, '{8'hC3, 8'hD4, 8'h00, 8'h00}, 2, "R2 program length");
    do_prog(1'b0, 1, 262, '{8'hA1, 8'hB2, 8'hC3, 8'hD4}, 4, "R3 program length");
    do_prog(1'b1, 2, 262, '{8'hA1, 8'hB2, 8'h00, 8'h00}, 2, "R2 program length");
    do_cmp(1'b0, 2, "R3 wrapped load matches");
    do_cmp(1'b1, 0, "R6 mismatch");
    do_cmp(1'b1, 1, "R2 page equals buffer");
  endtask

  task automatic t_xfer;
    do_xfer(1'b1, 0);
    do_cmp(1'b1, 0, "R5 transferred match");
    do_cmp(1'b1, 2, "R5 old data gone");
  endtask

  task automatic t_rewrite;
    do_rwr(1'b1, 1);
    do_cmp(1'b1, 1, "R7 buffer holds page");
    do_cmp(1'b1, 0, "R7 differs from erased");
  endtask

  task automatic t_busy_ignore;
    int c0;
    hdr(8'h82, 11'd3, 9'd5);
    put(8'h11);
    m_buf[5] = 8'h11;
    @(negedge clk); cs_n = 1'b1; c0 = cyc;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    put(8'h57);
    chk(st_vld == 1'b1, "R8 status while busy", int'(st_vld), 1);
    chk(st_byte[7] == 1'b0, "R8 busy bit", int'(st_byte[7]), 0);
    @(negedge clk); cs_n = 1'b1;
    hdr(8'h55, 11'd0, 9'd0);
    @(negedge clk); cs_n = 1'b1;
    for (int k = 0; k < 5000 && !ready; k++) @(negedge clk);
    chk(cyc - c0 == TE + 1, "R9 busy not extended", cyc - c0, TE + 1);
    for (int i = 0; i < PB; i++) m_arr[3*PB+i] = m_buf[i];
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(ready == 1'b1, "R9 no late launch", int'(ready), 1);
    end
    do_cmp(1'b1, 1, "R9 buffer untouched");
    do_cmp(1'b0, 3, "R2 program under load");
  endtask

  task automatic t_abort;
    @(negedge clk); cs_n = 1'b0;
    put(8'h53);
    put(8'h00);
    @(negedge clk); cs_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(ready == 1'b1, "R10 abort", int'(ready), 1);
    end
    hdr(8'h3C, 11'd0, 9'd0);
    @(negedge clk); cs_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(ready == 1'b1, "R10 unknown opcode", int'(ready), 1);
    end
    do_cmp(1'b0, 3, "R10 buffer unchanged");
  endtask

  initial begin
    for (int i = 0; i < PAGES*PB; i++) m_arr[i] = 8'hFF;
    for (int i = 0; i < 2*PB; i++) m_buf[i] = 8'hFF;
    t_reset();
    t_status_idle();
    t_prog_wrap();
    t_xfer();
    t_rewrite();
    t_busy_ignore();
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule